// File: doc/BRIEF.md
# Multi-Channel Bipolar Line Decoder (HDB3 / AMI)

This block takes retimed bipolar line symbols for several channels at once, with one positive-rail bit and one negative-rail bit per channel for each bit period. It turns them into single-rail binary data. Each channel decodes under one of two line rules, HDB3 or AMI. A global select chooses the rule, and a per-channel override can replace it. While decoding, every channel watches for line code violations and for runs of spaces that are too long. Each such event gives a one-cycle pulse and sets a sticky status bit. An interrupt line collects the enabled status bits. A global dual-rail switch turns the decoder off, so the two rails pass through unchanged and no events are raised.

Symbols enter through a valid/ready stream, and all channels advance together on each transfer. Decoded bits leave through a second valid/ready stream. The block holds one output register. The input is ready when that register is empty or is being drained in the same cycle (`in_ready = !out_valid || out_ready`). While `out_valid` is high and `out_ready` is low, the output stays frozen and no input is taken. HDB3 substitutions can only be undone after the fourth symbol of a group arrives. For that reason, every mode delays the data by three transfers.

Top module: `hdbx_decoder`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`. A transfer happens when `in_valid && in_ready`. While `out_valid && !out_ready`, `out_valid`, `out_dat` and `out_neg` stay unchanged.
- R2: After reset, `out_valid`, all pulses and all status bits are 0. The output word loaded by transfer k carries the decode of transfer k-3. The first three output words are all zero. `out_valid` is set by a transfer and cleared by `out_ready` when no transfer happens.
- R3: Each channel's rule is `ovr_code[i]` when `ovr_en[i]` is 1, and `code_glb` otherwise. In both cases 0 selects HDB3 and 1 selects AMI.
- R4: A mark is a symbol with either rail at 1. In AMI, a mark decodes to 1 and a space decodes to 0. A violation is a single-rail mark with the same polarity as the previous single-rail mark. The first mark after reset or after dual-rail mode cannot be a violation. In AMI, every violation raises `cv_pulse[i]`. A space never raises it.
- R5: In HDB3, a violation whose two preceding symbols are both spaces is a substitution. The violation and the three symbols before it all decode to 0, and no code-violation pulse is raised.
- R6: In HDB3, a violation with a mark in either of the two preceding symbols decodes to 1 and raises `cv_pulse[i]`.
- R7: A symbol with both rails at 1 decodes to 1, raises `cv_pulse[i]`, counts as a mark for the space run and the substitution check, and does not change the remembered polarity.
- R8: `exz_pulse[i]` goes high for one cycle when the run of consecutive spaces reaches `ZL_HDB3` under HDB3, or `ZL_AMI` under AMI. It does not pulse again until a mark ends the run.
- R9: While `dual_rail` is 1, `out_dat` and `out_neg` carry the positive and negative rails with the same three-transfer delay. No pulses are raised, the code selects are ignored, and the violation and space-run history is cleared.
- R10: Pulses are registered one cycle after their transfer. A pulse sets the matching `cv_sts` or `exz_sts` bit on the next edge. A 1 on the matching `cv_clr` or `exz_clr` bit clears the status bit. A set in the same cycle wins over a clear.
- R11: `irq` is 1 exactly when some status bit is 1 and its enable bit in `cv_en` or `exz_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Symbol word offered |
| in_ready | output | 1 | Symbol word accepted this cycle if valid |
| in_pos | input | NCH | Positive rail, one bit per channel |
| in_neg | input | NCH | Negative rail, one bit per channel |
| out_valid | output | 1 | Decoded word present |
| out_ready | input | 1 | Sink takes the decoded word |
| out_dat | output | NCH | Decoded bit, or positive rail in dual-rail mode |
| out_neg | output | NCH | Negative rail in dual-rail mode, 0 otherwise |
| dual_rail | input | 1 | Bypass decoding and monitoring |
| code_glb | input | 1 | Global rule: 0 HDB3, 1 AMI |
| ovr_en | input | NCH | Per-channel override enable |
| ovr_code | input | NCH | Per-channel rule when overridden |
| cv_pulse | output | NCH | Code-violation event pulse |
| exz_pulse | output | NCH | Excessive-spaces event pulse |
| cv_sts | output | NCH | Sticky code-violation status |
| exz_sts | output | NCH | Sticky excessive-spaces status |
| cv_clr | input | NCH | Write-one-to-clear for cv_sts |
| exz_clr | input | NCH | Write-one-to-clear for exz_sts |
| cv_en | input | NCH | Interrupt enable for cv_sts |
| exz_en | input | NCH | Interrupt enable for exz_sts |
| irq | output | 1 | OR of enabled status bits |

## Verification
The bench builds the block with NCH=3, ZL_HDB3=4 and ZL_AMI=8. Three channels let one run use the global select, an AMI override and an HDB3 override side by side, and each change of `code_glb` then moves only the channel that is not overridden. Lowering the AMI limit to 8 means space-heavy random traffic often reaches both the AMI and the HDB3 thresholds, including runs that stay saturated past the limit. Random back-pressure on `out_ready` runs alongside substitutions, violations, double-rail marks and a dual-rail phase whose code selects toggle on every cycle.

// File: rtl/hdbx_pkg.sv
package hdbx_pkg;
  typedef enum logic {RULE_HDB3 = 1'b0, RULE_AMI = 1'b1} rule_e;
  // symbols held back so a four-symbol substitution group can be erased
  localparam int GRP_DLY = 3;
endpackage

// File: rtl/hdbx_lane.sv
module hdbx_lane
  import hdbx_pkg::*;
#(
  parameter int ZL_HDB3 = 4,
  parameter int ZL_AMI  = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  acc,
  input  logic  dual,
  input  rule_e rule,
  input  logic  rail_p,
  input  logic  rail_n,
  output logic  dat_q,
  output logic  neg_q,
  output logic  cv_q,
  output logic  exz_q
);
  localparam int ZMAX = (ZL_HDB3 > ZL_AMI) ? ZL_HDB3 : ZL_AMI;
  localparam int ZW   = $clog2(ZMAX + 1);

  logic [GRP_DLY-1:0] dl_dat, dl_neg;   // bit 0 newest
  logic               m1, m2, have_mk, last_p;
  logic [ZW-1:0]      zc, zc_nxt, lim_m1;
  logic               mark, both, viol, subst, cv_ev, exz_ev;
  logic               new_dat, new_neg;

  always_comb begin
    mark    = rail_p | rail_n;
    both    = rail_p & rail_n;
    viol    = !dual && mark && !both && have_mk && (rail_p == last_p);
    subst   = (rule == RULE_HDB3) && viol && !m1 && !m2;
    cv_ev   = !dual && (both || (viol && !subst));
    lim_m1  = (rule == RULE_AMI) ? ZW'(ZL_AMI - 1) : ZW'(ZL_HDB3 - 1);
    exz_ev  = !dual && !mark && (zc == lim_m1);
    zc_nxt  = mark ? '0 : ((zc == ZW'(ZMAX)) ? zc : zc + 1'b1);
    new_dat = dual ? rail_p : (mark && !subst);
    new_neg = dual ? rail_n : 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dl_dat  <= '0;
      dl_neg  <= '0;
      dat_q   <= 1'b0;
      neg_q   <= 1'b0;
      m1      <= 1'b0;
      m2      <= 1'b0;
      have_mk <= 1'b0;
      last_p  <= 1'b0;
      zc      <= '0;
      cv_q    <= 1'b0;
      exz_q   <= 1'b0;
    end else begin
      cv_q  <= acc && cv_ev;
      exz_q <= acc && exz_ev;
      if (acc) begin
        dat_q <= subst ? 1'b0 : dl_dat[GRP_DLY-1];
        neg_q <= subst ? 1'b0 : dl_neg[GRP_DLY-1];
        if (subst) begin
          dl_dat <= '0;
          dl_neg <= '0;
        end else begin
          dl_dat <= {dl_dat[GRP_DLY-2:0], new_dat};
          dl_neg <= {dl_neg[GRP_DLY-2:0], new_neg};
        end
        if (dual) begin
          m1      <= 1'b0;
          m2      <= 1'b0;
          have_mk <= 1'b0;
          zc      <= '0;
        end else begin
          m1 <= mark;
          m2 <= m1;
          zc <= zc_nxt;
          if (mark && !both) begin
            last_p  <= rail_p;
            have_mk <= 1'b1;
          end
        end
      end
    end
  end

  // R9
  no_evt_dual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dual) |-> (!cv_q && !exz_q));

  // R4
  space_no_cv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !rail_p && !rail_n) |=> !cv_q);

  // R8
  exz_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exz_q |=> !exz_q);
endmodule

// File: rtl/hdbx_sticky.sv
module hdbx_sticky #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  input  logic [W-1:0] en,
  output logic [W-1:0] sts,
  output logic         irq_part
);
  always_ff @(posedge clk) begin
    if (!rst_n) sts <= '0;
    else        sts <= (sts & ~clr) | set;
  end

  assign irq_part = |(sts & en);

  // R10
  set_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set) |=> ((sts & $past(set)) == $past(set)));

  // R10
  clr_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr & ~set)) |=> ((sts & $past(clr & ~set)) == '0));
endmodule

// File: rtl/hdbx_decoder.sv
module hdbx_decoder
  import hdbx_pkg::*;
#(
  parameter int NCH     = 4,
  parameter int ZL_HDB3 = 4,
  parameter int ZL_AMI  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [NCH-1:0] in_pos,
  input  logic [NCH-1:0] in_neg,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [NCH-1:0] out_dat,
  output logic [NCH-1:0] out_neg,
  input  logic           dual_rail,
  input  logic           code_glb,
  input  logic [NCH-1:0] ovr_en,
  input  logic [NCH-1:0] ovr_code,
  output logic [NCH-1:0] cv_pulse,
  output logic [NCH-1:0] exz_pulse,
  output logic [NCH-1:0] cv_sts,
  output logic [NCH-1:0] exz_sts,
  input  logic [NCH-1:0] cv_clr,
  input  logic [NCH-1:0] exz_clr,
  input  logic [NCH-1:0] cv_en,
  input  logic [NCH-1:0] exz_en,
  output logic           irq
);
  logic acc, cv_irq, exz_irq;

  assign in_ready = !out_valid || out_ready;
  assign acc      = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)         out_valid <= 1'b0;
    else if (acc)       out_valid <= 1'b1;
    else if (out_ready) out_valid <= 1'b0;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_lane
    rule_e rule_i;
    assign rule_i = ovr_en[i] ? rule_e'(ovr_code[i]) : rule_e'(code_glb);

    hdbx_lane #(.ZL_HDB3(ZL_HDB3), .ZL_AMI(ZL_AMI)) u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .acc   (acc),
      .dual  (dual_rail),
      .rule  (rule_i),
      .rail_p(in_pos[i]),
      .rail_n(in_neg[i]),
      .dat_q (out_dat[i]),
      .neg_q (out_neg[i]),
      .cv_q  (cv_pulse[i]),
      .exz_q (exz_pulse[i])
    );
  end

  hdbx_sticky #(.W(NCH)) u_cv_sts (
    .clk(clk), .rst_n(rst_n), .set(cv_pulse), .clr(cv_clr),
    .en(cv_en), .sts(cv_sts), .irq_part(cv_irq)
  );

  hdbx_sticky #(.W(NCH)) u_exz_sts (
    .clk(clk), .rst_n(rst_n), .set(exz_pulse), .clr(exz_clr),
    .en(exz_en), .sts(exz_sts), .irq_part(exz_irq)
  );

  assign irq = cv_irq || exz_irq;

  // R1
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_dat) && $stable(out_neg)));

  // R2
  valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid));
endmodule

// File: tb/tb_hdbx_decoder.sv
module tb_hdbx_decoder;
  localparam int CLK_PER = 10;
  localparam int NCH     = 3;
  localparam int ZLH     = 4;
  localparam int ZLA     = 8;
  localparam int ZMAX    = 8;
  localparam int WD_LIM  = 150000;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_ready = 0, dual_rail = 0, code_glb = 0;
  logic [NCH-1:0] in_pos = '0, in_neg = '0, ovr_en = '0, ovr_code = '0;
  logic [NCH-1:0] cv_clr = '0, exz_clr = '0, cv_en = '0, exz_en = '0;
  logic in_ready, out_valid, irq;
  logic [NCH-1:0] out_dat, out_neg, cv_pulse, exz_pulse, cv_sts, exz_sts;

  hdbx_decoder #(.NCH(NCH), .ZL_HDB3(ZLH), .ZL_AMI(ZLA)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pos(in_pos), .in_neg(in_neg), .out_valid(out_valid), .out_ready(out_ready),
    .out_dat(out_dat), .out_neg(out_neg), .dual_rail(dual_rail), .code_glb(code_glb),
    .ovr_en(ovr_en), .ovr_code(ovr_code), .cv_pulse(cv_pulse), .exz_pulse(exz_pulse),
    .cv_sts(cv_sts), .exz_sts(exz_sts), .cv_clr(cv_clr), .exz_clr(exz_clr),
    .cv_en(cv_en), .exz_en(exz_en), .irq(irq)
  );

  always #(CLK_PER/2) clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  // behavioural reference state
  bit m_ov;
  bit [NCH-1:0] m_dat, m_neg, m_cvp, m_exp, m_cvs, m_exs;
  bit [1:0] pend [NCH][0:2];   // index 0 = oldest pending symbol {neg,dat}
  bit hm [NCH], lp [NCH], h1 [NCH], h2 [NCH];
  int zc [NCH];

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ov = 0; m_dat = '0; m_neg = '0; m_cvp = '0; m_exp = '0; m_cvs = '0; m_exs = '0;
      for (int c = 0; c < NCH; c++) begin
        for (int k = 0; k < 3; k++) pend[c][k] = 2'b00;
        hm[c] = 0; lp[c] = 0; h1[c] = 0; h2[c] = 0; zc[c] = 0;
      end
    end else begin
      bit acc;
      acc = in_valid && (!m_ov || out_ready);
      m_cvs = (m_cvs & ~cv_clr) | m_cvp;
      m_exs = (m_exs & ~exz_clr) | m_exp;
      m_cvp = '0; m_exp = '0;
      if (acc) begin
        for (int c = 0; c < NCH; c++) begin
          bit p, n, mk, bo, ami, vi, sub;
          bit [1:0] nd, outgoing;
          int lim;
          p = in_pos[c]; n = in_neg[c]; mk = p | n; bo = p & n;
          ami = ovr_en[c] ? ovr_code[c] : code_glb;
          sub = 0;
          if (dual_rail) begin
            nd = {n, p};
            hm[c] = 0; h1[c] = 0; h2[c] = 0; zc[c] = 0;
          end else begin
            vi = mk && !bo && hm[c] && (p == lp[c]);
            sub = !ami && vi && !h1[c] && !h2[c];
            m_cvp[c] = bo || (vi && !sub);
            lim = ami ? ZLA : ZLH;
            m_exp[c] = !mk && (zc[c] == lim - 1);
            if (mk) zc[c] = 0;
            else if (zc[c] < ZMAX) zc[c] = zc[c] + 1;
            if (mk && !bo) begin lp[c] = p; hm[c] = 1; end
            h2[c] = h1[c]; h1[c] = mk;
            nd = {1'b0, mk && !sub};
          end
          outgoing = sub ? 2'b00 : pend[c][0];
          pend[c][0] = pend[c][1]; pend[c][1] = pend[c][2]; pend[c][2] = nd;
          if (sub) for (int k = 0; k < 3; k++) pend[c][k] = 2'b00;
          m_dat[c] = outgoing[0]; m_neg[c] = outgoing[1];
        end
        m_ov = 1;
      end else if (out_ready) m_ov = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1 in_ready", in_ready, !m_ov || out_ready);
      chk("R2 out_valid", out_valid, m_ov);
      chk(dual_rail ? "R9 out_dat" : "R3 R5 out_dat", out_dat, m_dat);
      chk("R9 out_neg", out_neg, m_neg);
      chk("R4 R6 R7 cv_pulse", cv_pulse, m_cvp);
      chk("R8 exz_pulse", exz_pulse, m_exp);
      chk("R10 cv_sts", cv_sts, m_cvs);
      chk("R10 exz_sts", exz_sts, m_exs);
      chk("R11 irq", irq, |((m_cvs & cv_en) | (m_exs & exz_en)));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIM && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WD_LIM);
      summary();
      $finish;
    end
  end

  task automatic drive_sym(int zpct, int both_pct);
    for (int c = 0; c < NCH; c++) begin
      int r;
      r = $urandom % 100;
      if (r < zpct)                 begin in_pos[c] = 0; in_neg[c] = 0; end
      else if (r < zpct + both_pct) begin in_pos[c] = 1; in_neg[c] = 1; end
      else if ($urandom % 2 == 0)   begin in_pos[c] = 1; in_neg[c] = 0; end
      else                          begin in_pos[c] = 0; in_neg[c] = 1; end
    end
  endtask

  task automatic run_phase(int ncyc, int zpct, int both_pct, int rdy_pct, bit tog_code);
    for (int k = 0; k < ncyc; k++) begin
      @(posedge clk); #1;
      in_valid  = ($urandom % 4) != 0;
      out_ready = ($urandom % 100) < rdy_pct;
      drive_sym(zpct, both_pct);
      cv_clr  = (($urandom % 8) == 0) ? NCH'($urandom) : '0;
      exz_clr = (($urandom % 8) == 0) ? NCH'($urandom) : '0;
      if (($urandom % 32) == 0) begin cv_en = NCH'($urandom); exz_en = NCH'($urandom); end
      if (tog_code) begin code_glb = ~code_glb; ovr_code = NCH'($urandom); ovr_en = NCH'($urandom); end
    end
  endtask

  // directed HDB3 sequence on channel 1: + 0 0 0 + (000V), - 0 0 - (B00V), + + (bad V)
  task automatic directed();
    logic [1:0] seq [12];
    seq = '{2'b01, 2'b00, 2'b00, 2'b00, 2'b01, 2'b10, 2'b00, 2'b00, 2'b10, 2'b01, 2'b01, 2'b11};
    out_ready = 1; code_glb = 0; ovr_en = '0;
    for (int k = 0; k < 12; k++) begin
      @(posedge clk); #1;
      in_valid = 1;
      in_pos = '0; in_neg = '0;
      in_pos[1] = seq[k][0]; in_neg[1] = seq[k][1];
    end
    for (int k = 0; k < 5; k++) begin
      @(posedge clk); #1;
      in_pos = '0; in_neg = '0;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R2 reset state
    chk("R2 reset out_valid", out_valid, 0);
    chk("R2 reset cv_sts", cv_sts, 0);
    chk("R2 reset exz_sts", exz_sts, 0);
    chk("R11 reset irq", irq, 0);
    cv_en = '1; exz_en = '1;
    directed();
    code_glb = 0; ovr_en = '0;
    run_phase(3000, 50, 3, 90, 0);                           // all HDB3
    code_glb = 1;
    run_phase(3000, 80, 2, 80, 0);                           // all AMI
    code_glb = 0; ovr_en = 3'b101; ovr_code = 3'b001;
    run_phase(3000, 70, 3, 85, 0);                           // R3 mix of overrides
    code_glb = 1;
    run_phase(3000, 70, 3, 85, 0);
    dual_rail = 1;
    run_phase(2000, 50, 10, 80, 1);                          // R9 bypass
    dual_rail = 0; code_glb = 0; ovr_en = '0;
    run_phase(3000, 60, 3, 30, 0);                           // heavy back-pressure
    @(posedge clk); #1; in_valid = 0; out_ready = 1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule